// File: doc/BRIEF.md
# Producer-Consumer Latency Scoreboard

The block tracks, for every architectural register, which kind of instruction last wrote it, which execution pipe carried out that write, and how many cycles have passed since it issued. Each cycle the issue stage presents a set of source-register queries, and each query carries the role the operand will play. The role is one of: execute-pipe operand, load/store address, store data, hi read, lo read, or multiply/divide input. For each query the block answers with one ready bit. A source is ready once the time since its youngest producer issued covers the latency that the producer class, the producing pipe and the consumer role call for together.

All latencies sit in one editable table in the package. Writes take effect at the clock edge. A write that issues in the same cycle as a query of the same register is seen by that query with zero elapsed cycles. This lets zero-latency pairs co-issue and blocks every other pair.

Top module: `latency_scoreboard`

## Requirements
- R1: After reset, and for any register never written since then, every query reads ready in every role.
- R2: Role codes are 0 execute operand, 1 load/store address, 2 store data, 3 hi read, 4 lo read, 5 multiply/divide input; 6 and 7 act as 0. A query in cycle t+k of a register whose youngest write issued in cycle t is ready exactly when k is at least the latency. A write issuing in the query's own cycle counts as k = 0. Two queries with equal register and role always agree.
- R3: Load (class 1): address 3, store data 0, any other role 1.
- R4: Simple ALU (class 0). The unit code 1 is the load/store pipe; any other unit code is an execute pipe. On the load/store pipe: address 1, any other role 0. On an execute pipe: address 5, any other role 1.
- R5: 32-bit multiply (class 2): address 7, any other role 3. 64-bit multiply (class 3): address 7, hi read 4, any other role 3.
- R6: Move to hi/lo (class 4): hi read and lo read 3, any other role 4.
- R7: Move to FP register (class 5) is 5 in every role. Move from FP register (class 6) is 1 in every role.
- R8: FP classes, same latency in every role: basic op (class 7) 4, fused multiply-add (8) 8, single divide (9) 24, double divide (10) 32, single square root (11) 28, double square root (12) 40.
- R9: A new write to a register replaces the earlier entry. Readiness follows only the youngest producer.
- R10: With iss_valid_i low, or iss_dst_valid_i low, nothing is recorded and no query changes.
- R11: A query that is ready stays ready while its register and role hold and no new write to that register issues.
- R12: Class codes 13 to 15 have latency 1 in every role.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| iss_valid_i | input | 1 | An instruction issues this cycle |
| iss_dst_valid_i | input | 1 | The issuing instruction writes a register |
| iss_dst_i | input | 5 | Destination register index |
| iss_class_i | input | 4 | Producer class code |
| iss_unit_i | input | 2 | Pipe granted to the producer |
| src_idx_i | input | 10 | Source register index per query, query 0 in the low bits |
| src_role_i | input | 6 | Consumer role per query, 3 bits each |
| src_rdy_o | output | 2 | Ready bit per query |

## Verification
The ready bits come from the register state through combinational logic, so the answer for cycle t+k after an issue in cycle t appears within cycle t+k itself. A same-cycle write changes the answer in the issue cycle (k = 0). The bench drives each cycle's issue and queries just after the falling edge and compares one time unit later, before the next rising edge. Its model counts elapsed cycles as the difference between the current cycle number and the recorded issue cycle, and it records a write only at the rising edge that ends the issue cycle. Directed runs cover each latency at k = L-1 and k = L, and a random phase then concentrates writes and reads on eight registers.

// File: rtl/lsb_pkg.sv
package lsb_pkg;
  localparam int unsigned LAT_W = 6;
  typedef logic [LAT_W-1:0] lat_t;

  // producer classes
  localparam logic [3:0] CLS_ALU    = 4'd0;
  localparam logic [3:0] CLS_LOAD   = 4'd1;
  localparam logic [3:0] CLS_MUL32  = 4'd2;
  localparam logic [3:0] CLS_MUL64  = 4'd3;
  localparam logic [3:0] CLS_MTHILO = 4'd4;
  localparam logic [3:0] CLS_TOFP   = 4'd5;
  localparam logic [3:0] CLS_FROMFP = 4'd6;
  localparam logic [3:0] CLS_FPOP   = 4'd7;
  localparam logic [3:0] CLS_FMA    = 4'd8;
  localparam logic [3:0] CLS_FDIVS  = 4'd9;
  localparam logic [3:0] CLS_FDIVD  = 4'd10;
  localparam logic [3:0] CLS_FSQRTS = 4'd11;
  localparam logic [3:0] CLS_FSQRTD = 4'd12;

  // producing pipe
  localparam logic [1:0] UNIT_EX = 2'd0;
  localparam logic [1:0] UNIT_LS = 2'd1;

  // consumer roles
  localparam logic [2:0] ROLE_EXE   = 3'd0;
  localparam logic [2:0] ROLE_ADDR  = 3'd1;
  localparam logic [2:0] ROLE_SDATA = 3'd2;
  localparam logic [2:0] ROLE_RDHI  = 3'd3;
  localparam logic [2:0] ROLE_RDLO  = 3'd4;
  localparam logic [2:0] ROLE_MDIV  = 3'd5;

  // editable latency table
  localparam lat_t L_ALU_LS_ADDR = 6'd1;
  localparam lat_t L_ALU_LS_ANY  = 6'd0;
  localparam lat_t L_ALU_EX_ADDR = 6'd5;
  localparam lat_t L_ALU_EX_ANY  = 6'd1;
  localparam lat_t L_LD_ADDR     = 6'd3;
  localparam lat_t L_LD_SDATA    = 6'd0;
  localparam lat_t L_LD_ANY      = 6'd1;
  localparam lat_t L_MUL_ADDR    = 6'd7;
  localparam lat_t L_MUL_ANY     = 6'd3;
  localparam lat_t L_MUL64_HI    = 6'd4;
  localparam lat_t L_MT_HILO     = 6'd3;
  localparam lat_t L_MT_ANY      = 6'd4;
  localparam lat_t L_TOFP        = 6'd5;
  localparam lat_t L_FROMFP      = 6'd1;
  localparam lat_t L_FPOP        = 6'd4;
  localparam lat_t L_FMA         = 6'd8;
  localparam lat_t L_FDIVS       = 6'd24;
  localparam lat_t L_FDIVD       = 6'd32;
  localparam lat_t L_FSQRTS      = 6'd28;
  localparam lat_t L_FSQRTD      = 6'd40;
  localparam lat_t L_DEFAULT     = 6'd1;

  typedef struct packed {
    logic       vld;
    logic [3:0] cls;
    logic [1:0] unit;
    lat_t       age;   // cycles since issue, saturating
  } ent_t;
endpackage

// File: rtl/lsb_lat_table.sv
module lsb_lat_table
  import lsb_pkg::*;
(
  input  logic [3:0] cls_i,
  input  logic [1:0] unit_i,
  input  logic [2:0] role_i,
  output lat_t       lat_o
);
  always_comb begin
    lat_o = L_DEFAULT;
    case (cls_i)
      CLS_ALU: begin
        if (unit_i == UNIT_LS) lat_o = (role_i == ROLE_ADDR) ? L_ALU_LS_ADDR : L_ALU_LS_ANY;
        else                   lat_o = (role_i == ROLE_ADDR) ? L_ALU_EX_ADDR : L_ALU_EX_ANY;
      end
      CLS_LOAD: begin
        case (role_i)
          ROLE_ADDR:  lat_o = L_LD_ADDR;
          ROLE_SDATA: lat_o = L_LD_SDATA;
          default:    lat_o = L_LD_ANY;
        endcase
      end
      CLS_MUL32: lat_o = (role_i == ROLE_ADDR) ? L_MUL_ADDR : L_MUL_ANY;
      CLS_MUL64: begin
        case (role_i)
          ROLE_ADDR: lat_o = L_MUL_ADDR;
          ROLE_RDHI: lat_o = L_MUL64_HI;
          default:   lat_o = L_MUL_ANY;
        endcase
      end
      CLS_MTHILO: lat_o = (role_i == ROLE_RDHI || role_i == ROLE_RDLO) ? L_MT_HILO : L_MT_ANY;
      CLS_TOFP:   lat_o = L_TOFP;
      CLS_FROMFP: lat_o = L_FROMFP;
      CLS_FPOP:   lat_o = L_FPOP;
      CLS_FMA:    lat_o = L_FMA;
      CLS_FDIVS:  lat_o = L_FDIVS;
      CLS_FDIVD:  lat_o = L_FDIVD;
      CLS_FSQRTS: lat_o = L_FSQRTS;
      CLS_FSQRTD: lat_o = L_FSQRTD;
      default:    lat_o = L_DEFAULT;
    endcase
  end
endmodule

// File: rtl/lsb_entry.sv
module lsb_entry
  import lsb_pkg::*;
(
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       wr_i,
  input  logic [3:0] cls_i,
  input  logic [1:0] unit_i,
  output ent_t       ent_o
);
  ent_t ent_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ent_q <= '0;
    end else if (wr_i) begin
      // first cycle after the issue edge is elapsed cycle 1
      ent_q <= '{vld: 1'b1, cls: cls_i, unit: unit_i, age: lat_t'(1)};
    end else if (ent_q.vld && (ent_q.age != '1)) begin
      ent_q.age <= ent_q.age + lat_t'(1);
    end
  end

  assign ent_o = ent_q;
endmodule

// File: rtl/lsb_src_port.sv
module lsb_src_port
  import lsb_pkg::*;
#(
  parameter int unsigned NUM_REGS = 32,
  parameter int unsigned IDX_W    = 5
) (
  input  ent_t             ents_i [NUM_REGS],
  input  logic             iss_wr_i,
  input  logic [IDX_W-1:0] iss_dst_i,
  input  logic [3:0]       iss_cls_i,
  input  logic [1:0]       iss_unit_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic [2:0]       role_i,
  output logic             rdy_o
);
  ent_t sel;
  lat_t need;

  always_comb begin
    sel = '0;
    if (int'(idx_i) < int'(NUM_REGS)) sel = ents_i[idx_i];
    // a write issuing now is the youngest producer, zero cycles elapsed
    if (iss_wr_i && (iss_dst_i == idx_i))
      sel = '{vld: 1'b1, cls: iss_cls_i, unit: iss_unit_i, age: '0};
  end

  lsb_lat_table u_lat (
    .cls_i  (sel.cls),
    .unit_i (sel.unit),
    .role_i (role_i),
    .lat_o  (need)
  );

  assign rdy_o = !sel.vld || (sel.age >= need);
endmodule

// File: rtl/latency_scoreboard.sv
module latency_scoreboard
  import lsb_pkg::*;
#(
  parameter  int unsigned NUM_REGS = 32,
  parameter  int unsigned NUM_SRC  = 2,
  localparam int unsigned IDX_W    = $clog2(NUM_REGS)
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic                     iss_valid_i,
  input  logic                     iss_dst_valid_i,
  input  logic [IDX_W-1:0]         iss_dst_i,
  input  logic [3:0]               iss_class_i,
  input  logic [1:0]               iss_unit_i,
  input  logic [NUM_SRC*IDX_W-1:0] src_idx_i,
  input  logic [NUM_SRC*3-1:0]     src_role_i,
  output logic [NUM_SRC-1:0]       src_rdy_o
);
  logic iss_wr;
  ent_t ents [NUM_REGS];

  assign iss_wr = iss_valid_i && iss_dst_valid_i;

  for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
    lsb_entry u_ent (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .wr_i   (iss_wr && (iss_dst_i == IDX_W'(g))),
      .cls_i  (iss_class_i),
      .unit_i (iss_unit_i),
      .ent_o  (ents[g])
    );
  end

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    lsb_src_port #(
      .NUM_REGS (NUM_REGS),
      .IDX_W    (IDX_W)
    ) u_port (
      .ents_i     (ents),
      .iss_wr_i   (iss_wr),
      .iss_dst_i  (iss_dst_i),
      .iss_cls_i  (iss_class_i),
      .iss_unit_i (iss_unit_i),
      .idx_i      (src_idx_i[s*IDX_W +: IDX_W]),
      .role_i     (src_role_i[s*3 +: 3]),
      .rdy_o      (src_rdy_o[s])
    );
  end
endmodule

// File: rtl/lsb_checker.sv
module lsb_checker #(
  parameter int unsigned NUM_SRC = 2,
  parameter int unsigned IDX_W   = 5
) (
  input logic                     clk_i,
  input logic                     rst_ni,
  input logic                     iss_wr_i,
  input logic [IDX_W-1:0]         iss_dst_i,
  input logic [3:0]               iss_class_i,
  input logic [NUM_SRC*IDX_W-1:0] src_idx_i,
  input logic [NUM_SRC*3-1:0]     src_role_i,
  input logic [NUM_SRC-1:0]       src_rdy_o
);
  logic [NUM_SRC-1:0] hit;
  logic               long_cls;
  logic               fromfp_cls;

  assign long_cls   = (iss_class_i == 4'd5) || ((iss_class_i >= 4'd7) && (iss_class_i <= 4'd12));
  assign fromfp_cls = (iss_class_i == 4'd6);

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_chk
    assign hit[s] = iss_wr_i && (iss_dst_i == src_idx_i[s*IDX_W +: IDX_W]);

    // R11
    p_hold_ready_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(src_rdy_o[s]) && $stable(src_idx_i[s*IDX_W +: IDX_W]) &&
       $stable(src_role_i[s*3 +: 3]) && !hit[s]) |-> src_rdy_o[s]);

    // R8 and R7: multi-cycle producers never ready in their issue cycle
    p_fresh_busy_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (hit[s] && long_cls) |-> !src_rdy_o[s]);

    // R7
    p_fromfp_next_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ($past(hit[s] && fromfp_cls) && $stable(src_idx_i[s*IDX_W +: IDX_W]) && !hit[s])
      |-> src_rdy_o[s]);
  end

  if (NUM_SRC > 1) begin : g_pair
    // R2
    p_same_query_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((src_idx_i[0 +: IDX_W] == src_idx_i[IDX_W +: IDX_W]) &&
       (src_role_i[0 +: 3] == src_role_i[3 +: 3])) |-> (src_rdy_o[0] == src_rdy_o[1]));
  end
endmodule

bind latency_scoreboard lsb_checker #(
  .NUM_SRC (NUM_SRC),
  .IDX_W   (IDX_W)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .iss_wr_i    (iss_wr),
  .iss_dst_i   (iss_dst_i),
  .iss_class_i (iss_class_i),
  .src_idx_i   (src_idx_i),
  .src_role_i  (src_role_i),
  .src_rdy_o   (src_rdy_o)
);

// File: tb/latency_scoreboard_tb.sv
module latency_scoreboard_tb;
  localparam int CLK_PERIOD = 10;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic       iss_valid = 1'b0;
  logic       iss_dst_valid = 1'b0;
  logic [4:0] iss_dst = '0;
  logic [3:0] iss_class = '0;
  logic [1:0] iss_unit = '0;
  logic [9:0] src_idx = '0;
  logic [5:0] src_role = '0;
  logic [1:0] src_rdy;

  int checks = 0;
  int errors = 0;
  int cyc = 0;
  bit done = 1'b0;

  bit m_vld [32];
  int m_cyc [32];
  int m_cls [32];
  int m_unit [32];

  always #(CLK_PERIOD/2) clk = ~clk;

  latency_scoreboard u_dut (
    .clk_i           (clk),
    .rst_ni          (rst_ni),
    .iss_valid_i     (iss_valid),
    .iss_dst_valid_i (iss_dst_valid),
    .iss_dst_i       (iss_dst),
    .iss_class_i     (iss_class),
    .iss_unit_i      (iss_unit),
    .src_idx_i       (src_idx),
    .src_role_i      (src_role),
    .src_rdy_o       (src_rdy)
  );

  // latencies as stated in the requirements
  function automatic int exp_lat(int cls, int unit, int role);
    case (cls)
      0: if (unit == 1) return (role == 1) ? 1 : 0;
         else           return (role == 1) ? 5 : 1;
      1: return (role == 1) ? 3 : (role == 2) ? 0 : 1;
      2: return (role == 1) ? 7 : 3;
      3: return (role == 1) ? 7 : (role == 3) ? 4 : 3;
      4: return (role == 3 || role == 4) ? 3 : 4;
      5: return 5;
      6: return 1;
      7: return 4;
      8: return 8;
      9: return 24;
      10: return 32;
      11: return 28;
      12: return 40;
      default: return 1;
    endcase
  endfunction

  function automatic string cls_tag(int cls);
    case (cls)
      0: return "R4";
      1: return "R3";
      2, 3: return "R5";
      4: return "R6";
      5, 6: return "R7";
      7, 8, 9, 10, 11, 12: return "R8";
      default: return "R12";
    endcase
  endfunction

  task automatic step(input bit v, input bit dv, input int dst, input int cls, input int unit,
                      input int i0, input int r0, input int i1, input int r1, input string tag);
    int qi [2];
    int qr [2];
    qi[0] = i0; qi[1] = i1; qr[0] = r0; qr[1] = r1;
    iss_valid = v; iss_dst_valid = dv; iss_dst = 5'(dst);
    iss_class = 4'(cls); iss_unit = 2'(unit);
    src_idx = {5'(i1), 5'(i0)}; src_role = {3'(r1), 3'(r0)};
    #1;
    for (int s = 0; s < 2; s++) begin
      bit want;
      string t;
      if (v && dv && dst == qi[s]) begin
        want = (exp_lat(cls, unit, qr[s]) == 0); t = "R2";
      end else if (!m_vld[qi[s]]) begin
        want = 1'b1; t = "R1";
      end else begin
        want = ((cyc - m_cyc[qi[s]]) >= exp_lat(m_cls[qi[s]], m_unit[qi[s]], qr[s]));
        t = cls_tag(m_cls[qi[s]]);
      end
      if (tag != "") t = tag;
      checks++;
      if (src_rdy[s] !== want) begin
        errors++;
        $display("FAIL %s cycle %0d src%0d reg %0d role %0d: actual=%0b expected=%0b",
                 t, cyc, s, qi[s], qr[s], src_rdy[s], want);
      end
    end
    @(posedge clk);
    if (v && dv) begin
      m_vld[dst] = 1'b1; m_cyc[dst] = cyc; m_cls[dst] = cls; m_unit[dst] = unit;
    end
    cyc++;
    @(negedge clk);
  endtask

  task automatic issue(input int dst, input int cls, input int unit,
                       input int i0, input int r0, input int i1, input int r1, input string tag);
    step(1'b1, 1'b1, dst, cls, unit, i0, r0, i1, r1, tag);
  endtask

  task automatic watch(input int i0, input int r0, input int i1, input int r1,
                       input int n, input string tag);
    for (int k = 0; k < n; k++) step(1'b0, 1'b0, 0, 0, 0, i0, r0, i1, r1, tag);
  endtask

  initial begin
    for (int r = 0; r < 32; r++) m_vld[r] = 1'b0;
    repeat (3) @(negedge clk);
    #1;
    checks++;
    if (src_rdy !== 2'b11) begin
      errors++;
      $display("FAIL R1 in reset: actual=%b expected=11", src_rdy);
    end
    rst_ni = 1'b1;
    @(negedge clk);

    // R1: every register ready after reset
    for (int r = 0; r < 32; r++) step(1'b0, 1'b0, 0, 0, 0, r, r % 8, 31 - r, (r + 3) % 8, "R1");

    // R3: load
    issue(1, 1, 1, 1, 1, 1, 2, "R3");
    watch(1, 1, 1, 0, 5, "R3");
    // R4: simple ALU on execute pipe, then on load/store pipe
    issue(2, 0, 0, 2, 1, 2, 0, "R4");
    watch(2, 1, 2, 2, 7, "R4");
    issue(3, 0, 1, 3, 1, 3, 2, "R4");
    watch(3, 1, 3, 0, 3, "R4");
    // R5: multiplies
    issue(4, 2, 0, 4, 0, 4, 1, "R5");
    watch(4, 0, 4, 1, 9, "R5");
    issue(5, 3, 0, 5, 3, 5, 4, "R5");
    watch(5, 3, 5, 4, 6, "R5");
    issue(5, 3, 0, 5, 1, 5, 2, "R5");
    watch(5, 1, 5, 2, 9, "R5");
    // R6: move to hi/lo
    issue(6, 4, 0, 6, 3, 6, 5, "R6");
    watch(6, 3, 6, 5, 6, "R6");
    issue(6, 4, 0, 6, 4, 6, 0, "R6");
    watch(6, 4, 6, 0, 6, "R6");
    // R7: FP transfers
    issue(7, 5, 2, 7, 0, 7, 1, "R7");
    watch(7, 0, 7, 1, 7, "R7");
    issue(8, 6, 2, 8, 0, 8, 2, "R7");
    watch(8, 0, 8, 2, 3, "R7");
    // R8: FP arithmetic
    for (int c = 7; c <= 12; c++) begin
      issue(9 + c, c, 2, 9 + c, 0, 9 + c, c % 6, "R8");
      watch(9 + c, 0, 9 + c, 1, exp_lat(c, 2, 0) + 2, "R8");
    end
    // R12: unused class codes
    for (int c = 13; c <= 15; c++) begin
      issue(25, c, 0, 25, 1, 25, 0, "R12");
      watch(25, 1, 25, 3, 3, "R12");
    end
    // R9: younger short producer replaces an older long one
    issue(26, 10, 2, 26, 0, 0, 0, "R9");
    watch(26, 0, 26, 1, 2, "R9");
    issue(26, 6, 2, 26, 0, 26, 1, "R9");
    watch(26, 0, 26, 1, 3, "R9");
    // R2: same-cycle visibility of an issuing write
    issue(27, 1, 1, 27, 2, 27, 1, "R2");
    issue(28, 0, 1, 28, 0, 27, 1, "R2");
    watch(27, 1, 28, 1, 4, "R2");
    // R10: gated issues record nothing
    step(1'b0, 1'b1, 29, 10, 2, 29, 0, 29, 1, "R10");
    step(1'b1, 1'b0, 29, 12, 2, 29, 0, 29, 5, "R10");
    watch(29, 0, 29, 1, 3, "R10");
    // R11: ready holds with no new write
    issue(30, 7, 2, 30, 0, 31, 0, "R11");
    watch(30, 0, 30, 2, 12, "R11");

    // mixed traffic on a small register window
    for (int k = 0; k < 3000; k++) begin
      step(($urandom_range(0, 3) != 0), ($urandom_range(0, 4) != 0),
           $urandom_range(0, 7), $urandom_range(0, 15), $urandom_range(0, 3),
           $urandom_range(0, 7), $urandom_range(0, 7),
           $urandom_range(0, 7), $urandom_range(0, 7), "");
    end

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL R2 watchdog: actual=running expected=finished");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end
endmodule